// File: doc/BRIEF.md
# Host/Coprocessor Slot Mailbox

This block is a memory-mapped mailbox between a host processor and an embedded coprocessor. The host sees four 32-bit words on a simple register bus: a window that queues one slot toward the coprocessor per write, a control/status word for the host, a window that dequeues one reply slot per read, and a read-only status word describing the coprocessor side. Each direction owns a circular buffer of 32-bit slots. Each buffer has free-running 8-bit read and write pointers, and both pointers appear in the status words next to the buffer depth. Software therefore computes the filled count as the pointer difference modulo 256, and the free count as depth minus filled.

The coprocessor side is a plain port. It pops host slots, pushes reply slots, raises an interrupt request toward the host, and receives a one-cycle doorbell whenever the host writes the interrupt-generate bit. A reset/ready handshake lives in the same control word. Writing reset together with interrupt-generate empties both buffers. Reset then stays latched, and it freezes every window until the host clears it again, normally with ready and interrupt-generate set.

Top module: `mbox_regblock`

## Requirements
- R1: After reset both pointers of both buffers are zero, all control bits are zero, and each status word carries the parameter DEPTH in bits 31:24.
- R2: A bus write to word 0 appends the 32-bit data to the host buffer and increments the host write pointer (bits 23:16 of word 1). `cp_rdata` shows the oldest host slot, or zero when the buffer is empty. `cp_pop` removes that slot and increments the host read pointer (bits 15:8). A pop on an empty buffer changes nothing.
- R3: A write to word 0 while the host buffer holds DEPTH slots is discarded. The pointers keep their values, and bit 5 of word 1 becomes 1 and stays 1 until the buffers are cleared.
- R4: A bus read of word 2 returns the oldest reply slot and increments the reply read pointer (bits 15:8 of word 3). When the reply buffer is empty the read returns zero and the pointer does not move.
- R5: A `cp_push` while the reply buffer holds DEPTH slots is discarded and sets bit 5 of word 3, which is sticky.
- R6: Pointers wrap from 255 to 0. The filled count, write pointer minus read pointer modulo 256, never exceeds DEPTH.
- R7: Bit 1 of word 1 (interrupt status) is set by `cp_ig` and cleared by writing 1 to it; if both happen in the same cycle, the set wins. `irq` equals bit 0 (enable) AND bit 1.
- R8: Writing word 1 with bit 2 set drives `cp_doorbell` high for exactly the following cycle. Bit 2 always reads as zero.
- R9: Writing word 1 with bits 4 and 2 both set empties both buffers, zeroing pointers and overflow flags. While bit 4 reads 1, window writes, window reads, `cp_push` and `cp_pop` have no effect, and both the read window and `cp_rdata` return zero. Writing bit 4 as 0 resumes operation.
- R10: Bit 3 of word 1 is a read/write host-ready bit and is driven on `cp_host_ready`. Bit 3 of word 3 reflects the `cp_ready` input.
- R11: Writes to words 2 and 3 have no effect, and a read of word 0 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Bus access strobe, one access per cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Word index (0 TX window, 1 host CSR, 2 RX window, 3 coprocessor CSR) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational in the access cycle |
| irq | output | 1 | Host interrupt |
| cp_pop | input | 1 | Coprocessor consumes one host slot |
| cp_rdata | output | 32 | Oldest host slot, zero if none |
| cp_push | input | 1 | Coprocessor appends one reply slot |
| cp_wdata | input | 32 | Reply slot data |
| cp_ig | input | 1 | Coprocessor interrupt request to host |
| cp_ready | input | 1 | Coprocessor ready indication |
| cp_doorbell | output | 1 | One-cycle pulse after a host interrupt-generate write |
| cp_host_ready | output | 1 | Host-ready bit |

## Verification
The buffers are exercised by fills and drains spaced across separate cycles, by pushes past DEPTH on each side, and by reads and pops of empty buffers. These patterns separate the full and empty decisions from plain pointer movement. A long run of a push and a pop in the same cycle carries the pointers across the 255-to-0 wrap while the fill level holds at one. It exposes any confusion between the 8-bit published pointers and the storage index. Clears are issued with data in flight and with window accesses attempted while reset is latched. Simultaneous interrupt set and clear, back-to-back doorbell writes, and writes to the read-only words round out the control-word behaviour.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned PTR_W  = 8;

    typedef enum logic [1:0] {
        WIN_TX   = 2'd0,
        CSR_HOST = 2'd1,
        WIN_RX   = 2'd2,
        CSR_COP  = 2'd3
    } word_e;

    localparam int unsigned B_IE  = 0;
    localparam int unsigned B_IS  = 1;
    localparam int unsigned B_IG  = 2;
    localparam int unsigned B_RDY = 3;
    localparam int unsigned B_RST = 4;
    localparam int unsigned B_OVF = 5;
    localparam int unsigned RP_LSB  = 8;
    localparam int unsigned WP_LSB  = 16;
    localparam int unsigned DEP_LSB = 24;

    typedef struct packed {
        logic ie;
        logic is;
        logic rdy;
        logic rst;
        logic bell;
    } ctl_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic [7:0]   rp,
    output logic [7:0]   wp,
    output logic         ovf
);
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [IDX_W-1:0]        ridx;
        logic [IDX_W-1:0]        widx;
        logic [7:0]              rp;
        logic [7:0]              wp;
        logic                    ovf;
    } st_t;

    st_t s_q, s_d;
    logic [7:0] filled;
    logic       full, empty;

    assign filled = s_q.wp - s_q.rp;
    assign full   = (filled == 8'(DEPTH));
    assign empty  = (filled == 8'd0);

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.ridx = '0;
            s_d.widx = '0;
            s_d.rp   = '0;
            s_d.wp   = '0;
            s_d.ovf  = 1'b0;
        end else if (en) begin
            if (push) begin
                if (full) begin
                    s_d.ovf = 1'b1;
                end else begin
                    s_d.mem[s_q.widx] = push_data;
                    s_d.widx = (s_q.widx == LAST) ? '0 : s_q.widx + 1'b1;
                    s_d.wp   = s_q.wp + 8'd1;
                end
            end
            if (pop && !empty) begin
                s_d.ridx = (s_q.ridx == LAST) ? '0 : s_q.ridx + 1'b1;
                s_d.rp   = s_q.rp + 8'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head = (empty || !en) ? '0 : s_q.mem[s_q.ridx];
    assign rp   = s_q.rp;
    assign wp   = s_q.wp;
    assign ovf  = s_q.ovf;
endmodule

// File: rtl/mbox_ctl.sv
module mbox_ctl
    import mbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csr_wr,
    input  logic [4:0] wbits,
    input  logic       cp_ig,
    output ctl_t       ctl,
    output logic       clr
);
    ctl_t c_q, c_d;

    always_comb begin
        c_d      = c_q;
        c_d.bell = 1'b0;
        if (csr_wr) begin
            c_d.ie   = wbits[B_IE];
            c_d.rdy  = wbits[B_RDY];
            c_d.rst  = wbits[B_RST];
            c_d.bell = wbits[B_IG];
            if (wbits[B_IS]) c_d.is = 1'b0;
        end
        if (cp_ig) c_d.is = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ctl = c_q;
    assign clr = csr_wr && wbits[B_RST] && wbits[B_IG];
endmodule

// File: rtl/mbox_regblock.sv
module mbox_regblock
    import mbox_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_en,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq,
    input  logic        cp_pop,
    output logic [31:0] cp_rdata,
    input  logic        cp_push,
    input  logic [31:0] cp_wdata,
    input  logic        cp_ig,
    input  logic        cp_ready,
    output logic        cp_doorbell,
    output logic        cp_host_ready
);
    localparam int unsigned NDIR = 2;
    localparam logic [7:0]  DEP8 = 8'(DEPTH);

    word_e sel;
    logic  wr_tx, wr_csr, rd_rx;
    ctl_t  ctl;
    logic  clr;

    logic              f_push [NDIR];
    logic [DATA_W-1:0] f_data [NDIR];
    logic              f_pop  [NDIR];
    logic [DATA_W-1:0] f_head [NDIR];
    logic [7:0]        f_rp   [NDIR];
    logic [7:0]        f_wp   [NDIR];
    logic              f_ovf  [NDIR];

    logic [7:0] tx_rp, tx_wp, rx_rp, rx_wp;
    logic       tx_ovf, rx_ovf, is_bit, rst_bit;

    assign sel    = word_e'(reg_addr);
    assign wr_tx  = reg_en &&  reg_we && (sel == WIN_TX);
    assign wr_csr = reg_en &&  reg_we && (sel == CSR_HOST);
    assign rd_rx  = reg_en && !reg_we && (sel == WIN_RX);

    mbox_ctl u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .csr_wr (wr_csr),
        .wbits  (reg_wdata[4:0]),
        .cp_ig  (cp_ig),
        .ctl    (ctl),
        .clr    (clr)
    );

    assign f_push[0] = wr_tx;
    assign f_data[0] = reg_wdata;
    assign f_pop[0]  = cp_pop;
    assign f_push[1] = cp_push;
    assign f_data[1] = cp_wdata;
    assign f_pop[1]  = rd_rx;

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        mbox_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr),
            .en        (!ctl.rst),
            .push      (f_push[d]),
            .push_data (f_data[d]),
            .pop       (f_pop[d]),
            .head      (f_head[d]),
            .rp        (f_rp[d]),
            .wp        (f_wp[d]),
            .ovf       (f_ovf[d])
        );
    end

    assign tx_rp   = f_rp[0];
    assign tx_wp   = f_wp[0];
    assign rx_rp   = f_rp[1];
    assign rx_wp   = f_wp[1];
    assign tx_ovf  = f_ovf[0];
    assign rx_ovf  = f_ovf[1];
    assign is_bit  = ctl.is;
    assign rst_bit = ctl.rst;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            WIN_TX:   reg_rdata = '0;
            CSR_HOST: begin
                reg_rdata[DEP_LSB +: 8] = DEP8;
                reg_rdata[WP_LSB  +: 8] = tx_wp;
                reg_rdata[RP_LSB  +: 8] = tx_rp;
                reg_rdata[B_OVF]        = tx_ovf;
                reg_rdata[B_RST]        = ctl.rst;
                reg_rdata[B_RDY]        = ctl.rdy;
                reg_rdata[B_IS]         = ctl.is;
                reg_rdata[B_IE]         = ctl.ie;
            end
            WIN_RX:   reg_rdata = f_head[1];
            CSR_COP:  begin
                reg_rdata[DEP_LSB +: 8] = DEP8;
                reg_rdata[WP_LSB  +: 8] = rx_wp;
                reg_rdata[RP_LSB  +: 8] = rx_rp;
                reg_rdata[B_OVF]        = rx_ovf;
                reg_rdata[B_RDY]        = cp_ready;
            end
            default:  reg_rdata = '0;
        endcase
    end

    assign cp_rdata      = f_head[0];
    assign irq           = ctl.ie && ctl.is;
    assign cp_doorbell   = ctl.bell;
    assign cp_host_ready = ctl.rdy;
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
    parameter int unsigned DEPTH = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_en,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        cp_ig,
    input logic        cp_doorbell,
    input logic [7:0]  tx_rp,
    input logic [7:0]  tx_wp,
    input logic [7:0]  rx_rp,
    input logic [7:0]  rx_wp,
    input logic        tx_ovf,
    input logic        is_bit,
    input logic        rst_bit
);
    logic       w_csr, w_tx, r_rx, do_clr, w_bell;
    logic [7:0] tx_fill, rx_fill;

    assign w_csr   = reg_en &&  reg_we && (reg_addr == 2'd1);
    assign w_tx    = reg_en &&  reg_we && (reg_addr == 2'd0);
    assign r_rx    = reg_en && !reg_we && (reg_addr == 2'd2);
    assign do_clr  = w_csr && reg_wdata[4] && reg_wdata[2];
    assign w_bell  = w_csr && reg_wdata[2];
    assign tx_fill = tx_wp - tx_rp;
    assign rx_fill = rx_wp - rx_rp;

    AST_FILL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fill <= 8'(DEPTH)) && (rx_fill <= 8'(DEPTH))); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (w_tx && !rst_bit && tx_fill == 8'(DEPTH)) |=> (tx_ovf && $stable(tx_wp))); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ovf && !do_clr) |=> tx_ovf); // R3
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (r_rx && rx_fill == 8'd0) |=> $stable(rx_rp)); // R4
    AST_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cp_ig |=> is_bit); // R7
    AST_BELL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        w_bell |=> cp_doorbell); // R8
    AST_BELL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !w_bell |=> !cp_doorbell); // R8
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> (tx_rp == 8'd0 && tx_wp == 8'd0 && rx_rp == 8'd0 && rx_wp == 8'd0)); // R9
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_bit && !do_clr) |=> ($stable(tx_wp) && $stable(tx_rp) && $stable(rx_wp) && $stable(rx_rp))); // R9
endmodule

bind mbox_regblock mbox_checker #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_en      (reg_en),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .cp_ig       (cp_ig),
    .cp_doorbell (cp_doorbell),
    .tx_rp       (tx_rp),
    .tx_wp       (tx_wp),
    .rx_rp       (rx_rp),
    .rx_wp       (rx_wp),
    .tx_ovf      (tx_ovf),
    .is_bit      (is_bit),
    .rst_bit     (rst_bit)
);

// File: tb/sim_mbox_regblock.sv
module sim_mbox_regblock;
    localparam int CLK_PERIOD = 10;
    localparam int DEP        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic        cp_pop = 1'b0, cp_push = 1'b0, cp_ig = 1'b0, cp_ready = 1'b0;
    logic [31:0] cp_wdata = '0;
    logic [31:0] cp_rdata;
    logic        cp_doorbell, cp_host_ready;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    logic [31:0] hq[$];
    logic [31:0] rq[$];
    logic [7:0]  h_rp = 0, h_wp = 0, r_rp = 0, r_wp = 0;
    logic        m_hovf = 0, m_rovf = 0, m_ie = 0, m_is = 0, m_rdy = 0, m_rst = 0, m_bell = 0;

    mbox_regblock #(.DEPTH(DEP)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .cp_pop(cp_pop), .cp_rdata(cp_rdata), .cp_push(cp_push),
        .cp_wdata(cp_wdata), .cp_ig(cp_ig), .cp_ready(cp_ready),
        .cp_doorbell(cp_doorbell), .cp_host_ready(cp_host_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: act=%0d cycles exp=<20000", cycles);
            summary();
        end
    end

    // reference model update
    always @(posedge clk) begin
        if (rst_n) begin
            logic csr_w, clr, h_full, h_empty, r_full, r_empty;
            csr_w   = reg_en && reg_we && reg_addr == 2'd1;
            clr     = csr_w && reg_wdata[4] && reg_wdata[2];
            h_full  = hq.size() == DEP;
            h_empty = hq.size() == 0;
            r_full  = rq.size() == DEP;
            r_empty = rq.size() == 0;
            if (clr) begin
                hq.delete(); rq.delete();
                h_rp = 0; h_wp = 0; r_rp = 0; r_wp = 0; m_hovf = 0; m_rovf = 0;
            end else if (!m_rst) begin
                if (reg_en && reg_we && reg_addr == 2'd0) begin
                    if (h_full) m_hovf = 1;
                    else begin hq.push_back(reg_wdata); h_wp++; end
                end
                if (cp_pop && !h_empty) begin void'(hq.pop_front()); h_rp++; end
                if (cp_push) begin
                    if (r_full) m_rovf = 1;
                    else begin rq.push_back(cp_wdata); r_wp++; end
                end
                if (reg_en && !reg_we && reg_addr == 2'd2 && !r_empty) begin
                    void'(rq.pop_front()); r_rp++;
                end
            end
            m_bell = csr_w && reg_wdata[2];
            if (csr_w) begin
                m_ie = reg_wdata[0]; m_rdy = reg_wdata[3]; m_rst = reg_wdata[4];
                if (reg_wdata[1]) m_is = 0;
            end
            if (cp_ig) m_is = 1;
        end
    end

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h at cycle %0d", t, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] exp_rdata();
        case (reg_addr)
            2'd0: return 32'd0;
            2'd1: return {8'(DEP), h_wp, h_rp, 2'b00, m_hovf, m_rst, m_rdy, 1'b0, m_is, m_ie};
            2'd2: return (m_rst || rq.size() == 0) ? 32'd0 : rq[0];
            default: return {8'(DEP), r_wp, r_rp, 2'b00, m_rovf, 1'b0, cp_ready, 3'b000};
        endcase
    endfunction

    task automatic tick();
        #1;
        chk("R2 cp_rdata", cp_rdata, (m_rst || hq.size() == 0) ? 32'd0 : hq[0]);
        chk("R7 irq", {31'd0, irq}, {31'd0, m_ie & m_is});
        chk("R8 doorbell", {31'd0, cp_doorbell}, {31'd0, m_bell});
        chk("R10 host_ready", {31'd0, cp_host_ready}, {31'd0, m_rdy});
        if (reg_en && !reg_we) chk(tag, reg_rdata, exp_rdata());
        @(negedge clk);
        reg_en = 0; reg_we = 0; cp_pop = 0; cp_push = 0; cp_ig = 0;
    endtask

    task automatic hw(input logic [1:0] a, input logic [31:0] d);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d; tick();
    endtask
    task automatic hr(input logic [1:0] a);
        reg_en = 1; reg_we = 0; reg_addr = a; tick();
    endtask
    task automatic cpop();
        cp_pop = 1; tick();
    endtask
    task automatic cpush(input logic [31:0] d);
        cp_push = 1; cp_wdata = d; tick();
    endtask

    initial begin
        cp_ready = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        tag = "R1"; hr(2'd1); hr(2'd3); hr(2'd2);

        tag = "R2";
        for (int i = 0; i < 3; i++) hw(2'd0, 32'hA000_0000 + i);
        hr(2'd1);
        for (int i = 0; i < 4; i++) cpop();
        hr(2'd1);

        tag = "R3";
        for (int i = 0; i < DEP + 2; i++) hw(2'd0, 32'hB000_0000 + i);
        hr(2'd1);
        for (int i = 0; i < DEP; i++) cpop();
        hr(2'd1);

        tag = "R4";
        for (int i = 0; i < 3; i++) cpush(32'hC000_0000 + i);
        for (int i = 0; i < 4; i++) hr(2'd2);
        hr(2'd3);

        tag = "R5";
        for (int i = 0; i < DEP + 1; i++) cpush(32'hD000_0000 + i);
        hr(2'd3);
        hr(2'd2);

        tag = "R9";
        hw(2'd0, 32'hE000_0001);
        hw(2'd1, 32'h0000_0014);
        hr(2'd1); hr(2'd3); hr(2'd2);
        hw(2'd0, 32'hE000_0002);
        cpush(32'hE000_0003);
        hr(2'd1); hr(2'd3);
        hw(2'd1, 32'h0000_000C);
        hw(2'd0, 32'hE000_0004);
        hr(2'd1);
        cpop();

        tag = "R7";
        hw(2'd1, 32'h0000_0009);
        cp_ig = 1; tick();
        hr(2'd1);
        hw(2'd1, 32'h0000_000B);
        hr(2'd1);
        cp_ig = 1; reg_en = 1; reg_we = 1; reg_addr = 2'd1; reg_wdata = 32'h0000_000B; tick();
        hr(2'd1);

        tag = "R8";
        hw(2'd1, 32'h0000_000C);
        hw(2'd1, 32'h0000_000C);
        hw(2'd1, 32'h0000_0008);
        hr(2'd1);

        tag = "R6";
        for (int i = 0; i < 300; i++) begin
            cp_pop = 1; reg_en = 1; reg_we = 1; reg_addr = 2'd0; reg_wdata = 32'hF000_0000 + i;
            tick();
        end
        hr(2'd1);
        cpop();
        hr(2'd1);

        tag = "R11";
        cpush(32'h1111_2222);
        hw(2'd2, 32'hFFFF_FFFF);
        hw(2'd3, 32'hFFFF_FFFF);
        hw(2'd0, 32'h3333_4444);
        hr(2'd0); hr(2'd3); hr(2'd2);

        tag = "R10";
        cp_ready = 0;
        hw(2'd1, 32'h0);
        hr(2'd1); hr(2'd3);
        summary();
    end
endmodule